// File: doc/BRIEF.md
# Memory-Mapped Address Decoder

This block sits between a processor's single data port and three storage targets: a large main RAM, a smaller screen buffer and one keyboard word. The processor presents an address, a data word and a load strobe. The block uses the upper address bits to pick one target and passes that target its own sub-address. It sends the load strobe only to that target. The output is the selected target's current contents, read combinationally.

All three storage elements live inside the block. The two arrays and the keyboard word all update on the same rising clock edge. A write is seen on the output only after the edge that stores it. In the cycle of a write, the output still shows the old value.

The address width is a parameter. At 16 bits the main RAM holds 32K words and the screen buffer 8K words. The default of 12 bits keeps the arrays small: 2048 and 512 words.

Top module: `mmio_addr_dec`

## Requirements
- R1: When address bit ADDR_W-1 (the MSB) is 0, the access goes to main RAM, indexed by address bits ADDR_W-2..0.
- R2: When the MSB is 1 and address bit ADDR_W-3 is 1, the access goes to the single keyboard word. All address bits below ADDR_W-3 are ignored.
- R3: When the MSB is 1 and address bit ADDR_W-3 is 0, the access goes to the screen buffer, indexed by address bits ADDR_W-4..0.
- R4: In a cycle with load high, data_o shows the selected location's value from before the write. The new value appears on data_o in the cycle after the rising edge.
- R5: A load changes only the decoded target. Locations in the other two targets keep their values, including locations with the same low address bits.
- R6: Address bit ADDR_W-2 is ignored when the MSB is 1. The two addresses that differ only in that bit reach the same screen or keyboard location.
- R7: Asserting rst_ni low clears the keyboard word to 0.
- R8: In a cycle with load low, no target changes, whatever value data_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all targets update on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the keyboard word |
| addr_i | input | ADDR_W | Processor address |
| data_i | input | DATA_W | Write data |
| load_i | input | 1 | Write strobe for the decoded target |
| data_o | output | DATA_W | Current contents of the decoded location |

## Verification
Two situations are hard to reach. The first is a load that lands in one target while another target holds a value at the same low address bits. The second is an I/O access through the aliased copy of an address. To reach both, the bench fills every RAM and screen location with a distinct pattern, writing through both screen aliases. It then overwrites the whole screen through one alias only, and rereads all of RAM and both alias halves of the screen. The pre-write output is checked on every write once the location's old contents are known.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
  localparam int unsigned TGT_N = 3;
  localparam int unsigned TGT_RAM = 0;
  localparam int unsigned TGT_SCR = 1;
  localparam int unsigned TGT_KBD = 2;
  typedef logic [TGT_N-1:0] tgt_sel_t;
endpackage

// File: rtl/mmio_dec_decode.sv
module mmio_dec_decode
  import mmio_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_sel_t          sel_o,
  output logic [ADDR_W-2:0] ram_addr_o,
  output logic [ADDR_W-4:0] scr_addr_o
);
  localparam int unsigned IO_BIT  = ADDR_W - 1;
  localparam int unsigned KBD_BIT = ADDR_W - 3;

  always_comb begin
    sel_o = '0;
    if (!addr_i[IO_BIT])       sel_o[TGT_RAM] = 1'b1;
    else if (addr_i[KBD_BIT])  sel_o[TGT_KBD] = 1'b1;
    else                       sel_o[TGT_SCR] = 1'b1;
  end

  // bit ADDR_W-2 is intentionally dropped from the I/O sub-address
  assign ram_addr_o = addr_i[ADDR_W-2:0];
  assign scr_addr_o = addr_i[ADDR_W-4:0];
endmodule

// File: rtl/mmio_dec_bank.sv
module mmio_dec_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // read-before-write: output reflects stored word, not wdata_i
  assign rdata_o = mem_q[addr_i];

  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/mmio_dec_word.sv
module mmio_dec_word #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  assert_kbd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/mmio_addr_dec.sv
module mmio_addr_dec
  import mmio_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned RAM_AW = ADDR_W - 1;
  localparam int unsigned SCR_AW = ADDR_W - 3;

  tgt_sel_t            sel;
  tgt_sel_t            we_vec;
  logic [RAM_AW-1:0]   ram_addr;
  logic [SCR_AW-1:0]   scr_addr;
  logic [DATA_W-1:0]   ram_rd, scr_rd, kbd_q;

  mmio_dec_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i     (addr_i),
    .sel_o      (sel),
    .ram_addr_o (ram_addr),
    .scr_addr_o (scr_addr)
  );

  for (genvar g = 0; g < TGT_N; g++) begin : g_we
    assign we_vec[g] = load_i & sel[g];
  end

  mmio_dec_bank #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_vec[TGT_RAM]),
    .addr_i  (ram_addr),
    .wdata_i (data_i),
    .rdata_o (ram_rd)
  );

  mmio_dec_bank #(.AW(SCR_AW), .DW(DATA_W)) u_scr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_vec[TGT_SCR]),
    .addr_i  (scr_addr),
    .wdata_i (data_i),
    .rdata_o (scr_rd)
  );

  mmio_dec_word #(.DW(DATA_W)) u_kbd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_vec[TGT_KBD]),
    .wdata_i (data_i),
    .q_o     (kbd_q)
  );

  always_comb begin
    if (sel[TGT_KBD])      data_o = kbd_q;
    else if (sel[TGT_SCR]) data_o = scr_rd;
    else                   data_o = ram_rd;
  end

  logic past_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_q <= 1'b0;
    else         past_q <= 1'b1;
  end

  assert_single_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> $countones(we_vec) == 1);

  assert_no_stray_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |-> we_vec == '0);

  assert_output_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && !$past(load_i) && $stable(addr_i)) |-> $stable(data_o));
endmodule

// File: tb/mmio_addr_dec_tb.sv
module mmio_addr_dec_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int RAM_N = 1 << (AW - 1);
  localparam int SCR_N = 1 << (AW - 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          load = 1'b0;
  logic [DW-1:0] dout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] ram_m [RAM_N];
  bit            ram_v [RAM_N];
  logic [DW-1:0] scr_m [SCR_N];
  bit            scr_v [SCR_N];
  logic [DW-1:0] kbd_m = '0;

  always #5 clk = ~clk;

  mmio_addr_dec #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .load_i(load), .data_o(dout)
  );

  function automatic logic [DW-1:0] ram_pat(int a);
    return DW'(a * 40503) ^ 16'h5a5a;
  endfunction
  function automatic logic [DW-1:0] scr_pat(int s, int k);
    return DW'(s * 257 + k * 16'h3c1) ^ 16'h1234;
  endfunction
  function automatic logic [AW-1:0] scr_addr(int s, int alias_b);
    return AW'((1 << (AW - 1)) | (alias_b << (AW - 2)) | s);
  endfunction
  function automatic logic [AW-1:0] kbd_addr(int alias_b, int low);
    return AW'((1 << (AW - 1)) | (alias_b << (AW - 2)) | (1 << (AW - 3)) | (low % SCR_N));
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // one bus cycle: read check before the edge, model update after it
  task automatic cyc(logic [AW-1:0] a, logic [DW-1:0] d, logic ld, string tag);
    bit known;
    logic [DW-1:0] exp;
    int idx;
    @(negedge clk);
    addr = a; data = d; load = ld;
    #1;
    if (!a[AW-1]) begin
      idx = int'(a[AW-2:0]); known = ram_v[idx]; exp = ram_m[idx];
    end else if (a[AW-3]) begin
      idx = 0; known = 1'b1; exp = kbd_m;
    end else begin
      idx = int'(a[AW-4:0]); known = scr_v[idx]; exp = scr_m[idx];
    end
    if (known) check(tag, dout, exp);
    @(posedge clk);
    if (ld) begin
      if (!a[AW-1]) begin ram_m[idx] = d; ram_v[idx] = 1'b1; end
      else if (a[AW-3]) kbd_m = d;
      else begin scr_m[idx] = d; scr_v[idx] = 1'b1; end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RAM_N; i++) ram_v[i] = 1'b0;
    for (int i = 0; i < SCR_N; i++) scr_v[i] = 1'b0;
    addr = kbd_addr(0, 0);
    #12;
    check("R7", dout, '0);
    @(negedge clk); rst_n = 1'b1;

    // fill RAM and screen (both aliases), keyboard
    for (int a = 0; a < RAM_N; a++) cyc(AW'(a), ram_pat(a), 1'b1, "R1");
    for (int s = 0; s < SCR_N; s++) cyc(scr_addr(s, s & 1), scr_pat(s, 0), 1'b1, "R3");
    cyc(kbd_addr(0, 0), 16'hbeef, 1'b1, "R2");

    // R1 R8: readback with load low and noise on data_i
    for (int a = 0; a < RAM_N; a++) cyc(AW'(a), DW'($urandom), 1'b0, "R8");
    for (int a = 0; a < RAM_N; a++) cyc(AW'(a), '0, 1'b0, "R1");
    // R3 R6: screen seen through both aliases
    for (int s = 0; s < SCR_N; s++) begin
      cyc(scr_addr(s, 0), DW'($urandom), 1'b0, "R3");
      cyc(scr_addr(s, 1), DW'($urandom), 1'b0, "R6");
    end
    // R2 R6: keyboard through many low patterns and both aliases
    for (int k = 0; k < 16; k++) cyc(kbd_addr(k & 1, k * 37), '0, 1'b0, "R2");

    // R5: overwrite whole screen via alias 1, RAM must be untouched
    for (int s = 0; s < SCR_N; s++) cyc(scr_addr(s, 1), scr_pat(s, 1), 1'b1, "R4");
    for (int a = 0; a < RAM_N; a++) cyc(AW'(a), '0, 1'b0, "R5");
    for (int s = 0; s < SCR_N; s++) cyc(scr_addr(s, 0), '0, 1'b0, "R6");
    cyc(kbd_addr(1, 3), '0, 1'b0, "R5");
    // R5: keyboard write leaves screen and RAM slot 0 alone
    cyc(kbd_addr(1, 0), 16'h0f0f, 1'b1, "R4");
    cyc(scr_addr(0, 0), '0, 1'b0, "R5");
    cyc(AW'(0), '0, 1'b0, "R5");
    cyc(kbd_addr(0, 511), '0, 1'b0, "R6");

    // R4: write cycle shows old value, next cycle shows new
    cyc(AW'(RAM_N - 1), 16'h1111, 1'b1, "R4");
    cyc(AW'(RAM_N - 1), 16'h2222, 1'b1, "R4");
    cyc(AW'(RAM_N - 1), '0, 1'b0, "R4");
    cyc(scr_addr(SCR_N - 1, 0), 16'h3333, 1'b1, "R4");
    cyc(scr_addr(SCR_N - 1, 1), '0, 1'b0, "R4");
    cyc(kbd_addr(0, 5), 16'h4444, 1'b1, "R4");
    cyc(kbd_addr(1, 9), '0, 1'b0, "R4");

    // R7: reset clears keyboard again
    @(negedge clk); rst_n = 1'b0; addr = kbd_addr(0, 0); load = 1'b0;
    #1; check("R7", dout, '0);
    kbd_m = '0;
    @(negedge clk); rst_n = 1'b1;
    cyc(kbd_addr(1, 1), '0, 1'b0, "R7");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule